// File: doc/BRIEF.md
# Infrared SIR Receive Pulse Stretcher

This block turns the short pulses of a serial infrared receiver back into the level stream that an ordinary UART expects. It runs from the 16x baud clock that also drives the UART. Every falling edge on the infrared input announces one zero bit. The block answers each such edge by pulling its serial output low for one full bit time, which is sixteen clocks. A mark needs no activity: with no pulse, the output stays high.

The infrared input is asynchronous. It passes through a short synchronizer chain, and only the edge seen at the end of that chain counts. If a new falling edge arrives while the output is already low, the bit-time counter starts again from the top. A train of zero bits therefore appears as one unbroken low level, with no glitch at the bit boundaries. The length of the received pulse, and its trailing rising edge, have no influence on the output.

Top module: `ir_sir_rx`

## Requirements
- R1: Each isolated falling edge on `ir_rxd_i` yields exactly one low period on `rxd_o`, and two consecutive cycles never both register a falling edge.
- R2: `rxd_o` goes low on the clock edge that comes SYNC_STAGES+1 edges after the first edge that samples `ir_rxd_i` low, counting that first edge. With the defaults this is the third edge.
- R3: For an isolated pulse of any width from 1 to 16 cycles, `rxd_o` stays low for exactly BIT_CYCLES cycles. The default is 16.
- R4: A falling edge detected while `rxd_o` is low reloads the full bit time. Pulses spaced at most BIT_CYCLES cycles apart therefore give one unbroken low level, and this includes an edge that lands in the cycle in which the count would expire.
- R5: After the bit time expires with no new falling edge, `rxd_o` returns high on the next clock.
- R6: `rxd_o` is high (mark) while the reset `rst` is held, right after it, and whenever no pulse has arrived within the last bit time. The synchronous, active-high reset also ends a low period that is in progress.
- R7: Holding `ir_rxd_i` low for longer than a bit time does not extend the low on `rxd_o` beyond BIT_CYCLES cycles. Only edges count, not the line level.
- R8: A rising edge on `ir_rxd_i` neither starts, shortens nor lengthens a low period on `rxd_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16x baud clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_rxd_i | input | 1 | Asynchronous infrared receiver line; low while a pulse is present |
| rxd_o | output | 1 | Reconstructed UART serial line; high when idle |

## Verification
Two functions can fall in the same cycle: the expiry of the bit-time count and a new falling edge that reloads it. This happens when two pulses sit exactly BIT_CYCLES cycles apart. The bench sweeps the pulse spacing across that value, from wide gaps to tight back-to-back trains. It judges every cycle against a model built as the union of per-edge low windows. At a spacing of exactly one bit time, the model demands a seamless low level. One cycle more must show a single-cycle high gap.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

    localparam int unsigned DEF_BIT_CYCLES  = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic {
        LVL_SPACE = 1'b0,
        LVL_MARK  = 1'b1
    } line_lvl_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_evt_t;

    function automatic int unsigned cnt_width(input int unsigned span);
        return (span <= 2) ? 1 : $clog2(span);
    endfunction

endpackage

// File: rtl/ir_sync.sv
module ir_sync #(
    parameter int unsigned STAGES = irsir_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b1;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

    AST_SYNC_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> q == 1'b1); // R6
endmodule

// File: rtl/ir_edge.sv
module ir_edge
    import irsir_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl,
    output edge_evt_t evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= lvl;
    end

    always_comb begin
        evt.fall = prev_q & ~lvl;
        evt.rise = ~prev_q & lvl;
    end

    AST_SINGLE_FALL: assert property (@(posedge clk) disable iff (rst)
        evt.fall |=> !evt.fall); // R1
    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(evt.fall && evt.rise)); // R1
endmodule

// File: rtl/ir_stretch.sv
module ir_stretch
    import irsir_pkg::*;
#(
    parameter int unsigned BIT_CYCLES = DEF_BIT_CYCLES
) (
    input  logic      clk,
    input  logic      rst,
    input  edge_evt_t evt,
    output line_lvl_e lvl
);
    localparam int unsigned CW = cnt_width(BIT_CYCLES);
    localparam logic [CW-1:0] RELOAD = CW'(BIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= LVL_MARK;
            cnt <= '0;
        end else if (evt.fall) begin
            lvl <= LVL_SPACE;
            cnt <= RELOAD;
        end else if (lvl == LVL_SPACE) begin
            if (cnt == '0) lvl <= LVL_MARK;
            else           cnt <= cnt - 1'b1;
        end
    end

    AST_RESET_MARK: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> lvl == LVL_MARK); // R6
    AST_FALL_STARTS_SPACE: assert property (@(posedge clk) disable iff (rst)
        evt.fall |=> (lvl == LVL_SPACE && cnt == RELOAD)); // R2
    AST_SPACE_HELD: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_SPACE && cnt != '0) |=> lvl == LVL_SPACE); // R3
    AST_RETRIGGER_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_SPACE && evt.fall) |=> cnt == RELOAD); // R4
    AST_EXPIRY_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_SPACE && cnt == '0 && !evt.fall) |=> lvl == LVL_MARK); // R5
    AST_IDLE_STAYS_MARK: assert property (@(posedge clk) disable iff (rst)
        (lvl == LVL_MARK && !evt.fall) |=> lvl == LVL_MARK); // R6
    AST_RISE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (evt.rise && lvl == LVL_MARK) |=> lvl == LVL_MARK); // R8
endmodule

// File: rtl/ir_sir_rx.sv
module ir_sir_rx
    import irsir_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned BIT_CYCLES  = DEF_BIT_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic ir_rxd_i,
    output logic rxd_o
);
    logic      ir_sync_lvl;
    edge_evt_t ir_evt;
    line_lvl_e out_lvl;

    ir_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ir_rxd_i),
        .q   (ir_sync_lvl)
    );

    ir_edge u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (ir_sync_lvl),
        .evt (ir_evt)
    );

    ir_stretch #(.BIT_CYCLES(BIT_CYCLES)) u_stretch (
        .clk (clk),
        .rst (rst),
        .evt (ir_evt),
        .lvl (out_lvl)
    );

    assign rxd_o = out_lvl;

    AST_OUT_FOLLOWS_STRETCH: assert property (@(posedge clk) disable iff (rst)
        ir_evt.fall |=> !rxd_o); // R2
endmodule

// File: tb/tb_ir_sir_rx.sv
`timescale 1ns/1ps
module tb_ir_sir_rx;
    localparam int SYNC = 2;
    localparam int BIT  = 16;
    localparam int L    = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ir  = 1'b1;
    logic rxd;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #2.5 clk = ~clk;

    ir_sir_rx #(.SYNC_STAGES(SYNC), .BIT_CYCLES(BIT)) dut (
        .clk      (clk),
        .rst      (rst),
        .ir_rxd_i (ir),
        .rxd_o    (rxd)
    );

    task automatic check(input string tag, input logic act, input logic exp, input int t);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, t, act, exp);
        end
    endtask

    function automatic bit fall_at(input logic [L-1:0] p, input int n);
        if (n == 0) return !p[0];
        return p[n-1] && !p[n];
    endfunction

    // union of per-edge low windows [n+SYNC, n+SYNC+BIT-1]
    function automatic bit exp_low(input logic [L-1:0] p, input int t);
        for (int n = 0; n <= t; n++)
            if (fall_at(p, n) && t >= n + SYNC && t <= n + SYNC + BIT - 1) return 1;
        return 0;
    endfunction

    function automatic bit starts_low(input logic [L-1:0] p, input int t);
        return (t >= SYNC) && fall_at(p, t - SYNC);
    endfunction

    // drive one bit per cycle at the falling edge; check after the following rising edge
    task automatic run(input logic [L-1:0] p, input int len, input string tag, output int runs);
        logic prev_rxd = 1'b1;
        runs = 0;
        for (int t = 0; t < len; t++) begin
            bit e;
            string tg;
            ir = p[t];
            @(negedge clk);
            e = exp_low(p, t);
            if (e && starts_low(p, t))                    tg = "R2";
            else if (!e && t > 0 && exp_low(p, t - 1))    tg = "R5";
            else                                          tg = tag;
            check(tg, rxd, e ? 1'b0 : 1'b1, t);
            if (prev_rxd && !rxd) runs++;
            prev_rxd = rxd;
        end
    endtask

    initial begin
        int runs;
        logic [L-1:0] p;
        repeat (3) @(negedge clk);
        check("R6", rxd, 1'b1, -1);
        rst = 1'b0;

        // pulse width sweep: short pulses (R3, rising edge R8) and long held levels (R7)
        for (int w = 1; w <= 40; w++) begin
            p = '1;
            for (int b = 0; b < w; b++) p[4 + b] = 1'b0;
            run(p, 4 + w + 24, (w <= BIT) ? "R3,R8" : "R7", runs);
            check("R1", runs == 1, 1'b1, w);
        end

        // two pulses swept across the reload/expiry coincidence
        for (int s = 4; s <= 24; s++) begin
            p = '1;
            for (int b = 0; b < 3; b++) begin
                p[4 + b]     = 1'b0;
                p[4 + s + b] = 1'b0;
            end
            run(p, 4 + s + 3 + 24, "R4", runs);
            check("R4", runs == ((s <= BIT) ? 1 : 2), 1'b1, s);
        end

        // train of zero bits one bit time apart: one unbroken low
        p = '1;
        for (int k = 0; k < 6; k++) begin
            p[4 + 16 * k]     = 1'b0;
            p[4 + 16 * k + 1] = 1'b0;
        end
        run(p, 4 + 96 + 24, "R4", runs);
        check("R4", runs == 1, 1'b1, 6);

        // reset during a low period
        ir = 1'b0;
        repeat (2) @(negedge clk);
        ir = 1'b1;
        repeat (6) @(negedge clk);
        check("R2", rxd, 1'b0, 0);
        rst = 1'b1;
        @(negedge clk);
        check("R6", rxd, 1'b1, 0);
        rst = 1'b0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            check("R6", rxd, 1'b1, t);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule